// File: doc/BRIEF.md
# Two-Channel Reloadable Event/Tick Down Counter

This block holds two independent 8-bit down counters. Each channel counts falling edges of one of two inputs: a prescaled tick line supplied from outside, or an external event line. Both lines are level signals that the block samples in its own clock domain. Each channel has its own control register, reload register and counter. When a running counter steps down from 00h it reloads, emits a one-cycle underflow pulse and toggles an output line that an enable bit gates.

A write to the run bit only records a request. The counter takes up the new run state at the next falling edge of its selected counting input. On a stop request, that edge still performs one final decrement. The run bit always reads back the state the counter is really in. Software reads the count as two 4-bit halves, low half first. Reading the low half captures the high half, so the two halves always belong to the same count value.

The register port is a set of plain strobes. Writes and reads complete in the cycle their enable is sampled, and nothing ever applies back-pressure. Address bits [1:0] select the field and the bits above them select the channel.

Top module: `prog_down_timer`

## Requirements
- R1: After reset, every readable field of both channels reads 0 and both timer outputs are 0.
- R2: While a channel runs, each falling edge of its selected counting input lowers its count by exactly one (for example 42h, 41h, 40h, 3Fh).
- R3: Control field 0 bit 0 records a run request. The request takes effect only at the next falling edge of the selected counting input. Reading bit 0 returns the actual run state, not the value written. The falling edge that starts the counter does not decrement.
- R4: When stop is requested, the counter decrements once more at the applying edge and then stays unchanged on later edges.
- R5: Control bit 1 set selects the event input as the counting input and the tick input is ignored. With no event edges, a pending run request is never applied.
- R6: Reading field 2 returns count bits [3:0] and captures count bits [7:4]. Field 3 returns the captured bits, even if the count has changed since.
- R7: A counting edge at count 00h reloads the count from field 1 and raises the channel's underflow output for exactly one clock cycle.
- R8: Each underflow toggles an internal output state. The timer output shows that state ANDed with control bit 2, through a register.
- R9: Writing control with bit 3 set copies the reload value into the count within one clock, without changing the run state. Bit 3 reads back as 0.
- R10: Activity on one channel never changes the count, run state, underflow output or timer output of the other channel. Addresses 0 to 3 belong to channel 0 and addresses 4 to 7 to channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tclk_i | input | 2 | Prescaled tick line per channel |
| evt_i | input | 2 | External event line per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address {channel, field} |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (captures the high half on field 2) |
| rd_addr | input | 3 | Read address {channel, field} |
| rd_data | output | 8 | Read data for rd_addr |
| uf_o | output | 2 | One-cycle underflow pulse per channel |
| tout_o | output | 2 | Gated timer output per channel |

## Verification
The hardest states to reach are those where the register view and the counter disagree. One is a run bit that still reads 1 after stop was written. Another is a high half that no longer matches the live count. The stimulus reaches them by placing a single counting edge between a write and its read-back, or between the low-half read and the high-half read. It also runs event mode with only tick activity, to show that the pending request stays unapplied until an event edge arrives.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  typedef enum logic [1:0] {
    FLD_CTRL   = 2'd0,
    FLD_RELOAD = 2'd1,
    FLD_CNT_LO = 2'd2,
    FLD_CNT_HI = 2'd3
  } fld_e;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_MODE = 1;
  localparam int CTRL_TEN  = 2;
  localparam int CTRL_LOAD = 3;
  localparam int NIB       = 4;
endpackage

// File: rtl/pdt_fall_sync.sv
module pdt_fall_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic fall_o
);
  // sh[STAGES-1] is the synchronised level; sh[STAGES] is its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], d_i};
  end

  assign fall_o = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/pdt_channel.sv
module pdt_channel
  import pdt_pkg::*;
#(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tclk_i,
  input  logic          evt_i,
  input  logic          wr_ctrl,
  input  logic          wr_rld,
  input  logic [W-1:0]  wdata,
  input  logic          rd_lo,
  output logic [W-1:0]  cnt_o,
  output logic [W-1:0]  rld_o,
  output logic [W-NIB-1:0] hold_o,
  output logic          run_o,
  output logic          mode_o,
  output logic          ten_o,
  output logic          uf_o,
  output logic          tout_o,
  output logic          ld_o,
  output logic          fall_o
);
  logic tk_fall, ev_fall, fall;
  logic run_req, run_q, mode_q, ten_q, tog_q, uf_q, tout_q;
  logic [W-1:0] cnt_q, rld_q;
  logic [W-NIB-1:0] hold_q;
  logic ld;

  pdt_fall_sync #(.STAGES(SYNC)) u_tick_sync (
    .clk(clk), .rst_n(rst_n), .d_i(tclk_i), .fall_o(tk_fall)
  );
  pdt_fall_sync #(.STAGES(SYNC)) u_evt_sync (
    .clk(clk), .rst_n(rst_n), .d_i(evt_i), .fall_o(ev_fall)
  );

  assign fall = mode_q ? ev_fall : tk_fall;
  assign ld   = wr_ctrl & wdata[CTRL_LOAD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_req <= 1'b0;
      run_q   <= 1'b0;
      mode_q  <= 1'b0;
      ten_q   <= 1'b0;
      tog_q   <= 1'b0;
      uf_q    <= 1'b0;
      tout_q  <= 1'b0;
      cnt_q   <= '0;
      rld_q   <= '0;
      hold_q  <= '0;
    end else begin
      uf_q <= 1'b0;
      if (wr_ctrl) begin
        run_req <= wdata[CTRL_RUN];
        mode_q  <= wdata[CTRL_MODE];
        ten_q   <= wdata[CTRL_TEN];
      end
      if (wr_rld) rld_q <= wdata;
      // run state follows the request only on a counting edge
      if (fall) run_q <= run_req;
      if (ld) begin
        cnt_q <= rld_q;
      end else if (fall && run_q) begin
        if (cnt_q == '0) begin
          cnt_q <= rld_q;
          uf_q  <= 1'b1;
          tog_q <= ~tog_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (rd_lo) hold_q <= cnt_q[W-1:NIB];
      tout_q <= tog_q & ten_q;
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign hold_o = hold_q;
  assign run_o  = run_q;
  assign mode_o = mode_q;
  assign ten_o  = ten_q;
  assign uf_o   = uf_q;
  assign tout_o = tout_q;
  assign ld_o   = ld;
  assign fall_o = fall;
endmodule

// File: rtl/prog_down_timer.sv
module prog_down_timer
  import pdt_pkg::*;
#(
  parameter int CHANNELS = 2,
  parameter int W        = 8,
  parameter int SYNC     = 2,
  localparam int CHW     = (CHANNELS > 1) ? $clog2(CHANNELS) : 1,
  localparam int AW      = CHW + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] tclk_i,
  input  logic [CHANNELS-1:0] evt_i,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [W-1:0]        wr_data,
  input  logic                rd_en,
  input  logic [AW-1:0]       rd_addr,
  output logic [W-1:0]        rd_data,
  output logic [CHANNELS-1:0] uf_o,
  output logic [CHANNELS-1:0] tout_o
);
  logic [CHANNELS-1:0][W-1:0]     cnt_v, rld_v;
  logic [CHANNELS-1:0][W-NIB-1:0] hold_v;
  logic [CHANNELS-1:0]            run_v, mode_v, ten_v, ld_v, fall_v;

  fld_e wr_fld, rd_fld;
  assign wr_fld = fld_e'(wr_addr[1:0]);
  assign rd_fld = fld_e'(rd_addr[1:0]);

  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    logic wsel, rsel;
    assign wsel = wr_en && (wr_addr[AW-1:2] == CHW'(g));
    assign rsel = rd_en && (rd_addr[AW-1:2] == CHW'(g));

    pdt_channel #(.W(W), .SYNC(SYNC)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tclk_i (tclk_i[g]),
      .evt_i  (evt_i[g]),
      .wr_ctrl(wsel && wr_fld == FLD_CTRL),
      .wr_rld (wsel && wr_fld == FLD_RELOAD),
      .wdata  (wr_data),
      .rd_lo  (rsel && rd_fld == FLD_CNT_LO),
      .cnt_o  (cnt_v[g]),
      .rld_o  (rld_v[g]),
      .hold_o (hold_v[g]),
      .run_o  (run_v[g]),
      .mode_o (mode_v[g]),
      .ten_o  (ten_v[g]),
      .uf_o   (uf_o[g]),
      .tout_o (tout_o[g]),
      .ld_o   (ld_v[g]),
      .fall_o (fall_v[g])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < CHANNELS; i++) begin
      if (rd_addr[AW-1:2] == CHW'(i)) begin
        unique case (rd_fld)
          FLD_CTRL:   rd_data = {{(W-3){1'b0}}, ten_v[i], mode_v[i], run_v[i]};
          FLD_RELOAD: rd_data = rld_v[i];
          FLD_CNT_LO: rd_data = {{(W-NIB){1'b0}}, cnt_v[i][NIB-1:0]};
          FLD_CNT_HI: rd_data = {{NIB{1'b0}}, hold_v[i]};
          default:    rd_data = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pdt_checker.sv
module pdt_checker #(
  parameter int N = 2,
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      uf,
  input logic [N-1:0][W-1:0] cnt,
  input logic [N-1:0][W-1:0] rld,
  input logic [N-1:0]      run,
  input logic [N-1:0]      ld,
  input logic [N-1:0]      fall
);
  for (genvar i = 0; i < N; i++) begin : g_chk
    // R7: underflow pulse lasts a single cycle
    assert_uf_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      uf[i] |=> !uf[i]);
    // R7: the pulse comes with the reload value in the counter
    assert_uf_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      uf[i] |-> cnt[i] == $past(rld[i]));
    // R2: any other count change is a step of one
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cnt[i]) && !uf[i] && !$past(ld[i])) |-> cnt[i] == W'($past(cnt[i]) - 1'b1));
    // R3: run state moves only on a counting edge
    assert_run_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(run[i]) |-> $past(fall[i]));
    // R4: stopping edge carries one last decrement
    assert_stop_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run[i]) |-> (cnt[i] == W'($past(cnt[i]) - 1'b1) || uf[i] || $past(ld[i])));
  end
endmodule

bind prog_down_timer pdt_checker #(.N(CHANNELS), .W(W)) u_pdt_checker (
  .clk(clk), .rst_n(rst_n), .uf(uf_o), .cnt(cnt_v), .rld(rld_v),
  .run(run_v), .ld(ld_v), .fall(fall_v)
);

// File: tb/test_prog_down_timer.sv
module test_prog_down_timer;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] tclk = '0, evt = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] uf_o, tout_o;

  int errors = 0, checks = 0;
  int ufc0 = 0, ufc1 = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] want; string tag; } item_t;
  item_t sb[$];
  event rd_ev;

  always #(PERIOD/2) clk = ~clk;

  prog_down_timer i_prog_down_timer (
    .clk(clk), .rst_n(rst_n), .tclk_i(tclk), .evt_i(evt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .uf_o(uf_o), .tout_o(tout_o)
  );

  always @(negedge clk) begin
    if (uf_o[0]) ufc0++;
    if (uf_o[1]) ufc1++;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] want);
    checks++;
    if (act !== want) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, want);
    end
  endtask

  // monitor: compares each read with the item queued by the driver
  always @(rd_ev) begin
    if (sb.size() == 0) begin
      checks++; errors++;
      $display("FAIL scoreboard empty actual=%h expected=none", rd_data);
    end else begin
      item_t it;
      it = sb.pop_front();
      chk(it.tag, rd_data, it.want);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] want, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    sb.push_back('{want, tag});
    #(PERIOD/4);
    -> rd_ev;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tick(input int ch, input bit use_evt);
    if (use_evt) evt[ch] = 1'b1; else tclk[ch] = 1'b1;
    repeat (4) @(negedge clk);
    if (use_evt) evt[ch] = 1'b0; else tclk[ch] = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, 8'h00, "R1 ctrl0");
    rd(3'd1, 8'h00, "R1 reload0");
    rd(3'd2, 8'h00, "R1 lo0");
    rd(3'd3, 8'h00, "R1 hi0");
    rd(3'd6, 8'h00, "R1 lo1");
    chk("R1 tout", {6'd0, tout_o}, 8'h00);

    // R9 load without run
    wr(3'd1, 8'h42);
    wr(3'd0, 8'h08);
    rd(3'd2, 8'h02, "R9 lo after load");
    rd(3'd3, 8'h04, "R9 hi after load");
    rd(3'd0, 8'h00, "R9 run unchanged, load bit reads 0");

    // R3 run request deferred to the next falling edge
    wr(3'd0, 8'h01);
    rd(3'd0, 8'h00, "R3 run not yet applied");
    tick(0, 1'b0);
    rd(3'd0, 8'h01, "R3 run applied at edge");
    rd(3'd2, 8'h02, "R3 start edge does not decrement");

    // R2 decrement sequence
    tick(0, 1'b0);
    rd(3'd2, 8'h01, "R2 42->41");
    tick(0, 1'b0);
    rd(3'd2, 8'h00, "R2 41->40 lo");
    // R6 capture: count moves between the two half reads
    tick(0, 1'b0);
    rd(3'd3, 8'h04, "R6 hi keeps captured half");
    rd(3'd2, 8'h0F, "R2 40->3F lo");
    rd(3'd3, 8'h03, "R6 hi of 3F");

    // R4 stop: one more decrement then halt
    wr(3'd0, 8'h00);
    rd(3'd0, 8'h01, "R4 run still reads 1 after stop write");
    tick(0, 1'b0);
    rd(3'd0, 8'h00, "R4 run cleared at edge");
    rd(3'd2, 8'h0E, "R4 last decrement to 3E");
    tick(0, 1'b0);
    rd(3'd2, 8'h0E, "R4 halted");
    rd(3'd3, 8'h03, "R4 halted hi");

    // R10 channel 1 untouched
    rd(3'd6, 8'h00, "R10 ch1 count");
    rd(3'd4, 8'h00, "R10 ch1 ctrl");

    // R5 event mode
    wr(3'd0, 8'h03);
    tick(0, 1'b0);
    tick(0, 1'b0);
    rd(3'd0, 8'h02, "R5 no event edge, run pending");
    rd(3'd2, 8'h0E, "R5 tick ignored");
    tick(0, 1'b1);
    rd(3'd0, 8'h03, "R5 event edge applies run");
    tick(0, 1'b1);
    rd(3'd2, 8'h0D, "R5 event decrement");
    tick(0, 1'b0);
    rd(3'd2, 8'h0D, "R5 tick ignored while running");

    // R7/R8 underflow
    wr(3'd1, 8'h02);
    wr(3'd0, 8'h0D);
    rd(3'd2, 8'h02, "R9 load while running");
    tick(0, 1'b0);
    tick(0, 1'b0);
    rd(3'd2, 8'h00, "R2 reached 00");
    chk("R7 no pulse before underflow", ufc0[7:0], 8'd0);
    tick(0, 1'b0);
    rd(3'd2, 8'h02, "R7 reload after 00");
    chk("R7 single pulse", ufc0[7:0], 8'd1);
    chk("R8 tout after toggle", {7'd0, tout_o[0]}, 8'd1);
    wr(3'd0, 8'h01);
    repeat (2) @(negedge clk);
    chk("R8 tout gated off", {7'd0, tout_o[0]}, 8'd0);
    wr(3'd0, 8'h05);
    repeat (2) @(negedge clk);
    chk("R8 tout gated on", {7'd0, tout_o[0]}, 8'd1);
    tick(0, 1'b0);
    tick(0, 1'b0);
    tick(0, 1'b0);
    chk("R7 second pulse", ufc0[7:0], 8'd2);
    chk("R8 tout toggled back", {7'd0, tout_o[0]}, 8'd0);

    // R10 channel 1 underflow, channel 0 unaffected
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h0D);
    tick(1, 1'b0);
    tick(1, 1'b0);
    chk("R10 ch1 pulse", ufc1[7:0], 8'd1);
    chk("R10 ch1 tout", {7'd0, tout_o[1]}, 8'd1);
    chk("R10 ch0 pulses unchanged", ufc0[7:0], 8'd2);
    rd(3'd2, 8'h02, "R10 ch0 count unchanged");
    rd(3'd4, 8'h05, "R10 ch1 ctrl running");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule